// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block screens the first bytes of each incoming Ethernet frame and decides whether the frame should be kept. It watches a byte-wide receive stream that begins at the first destination-address byte, right after the start-of-frame delimiter. A valid strobe qualifies each byte, and a start strobe marks the first byte of a frame. The block gathers the 48-bit destination address and tests it against four exact-match slots, the all-ones broadcast address and a 64-entry hash table. It then captures the two type bytes that follow the source address and compares them with a programmable type value.

A 32-bit write port loads the slots, the hash table, the type value and three configuration bits. At the start of each frame the block copies all of these settings into shadow storage. Writes made while a frame is in flight therefore only affect the next frame. The accept decision and the flags for each source are registered. They stay stable until the next frame begins.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `decValid` and `typeValid` are 0 and every exact-match slot is inactive. A frame whose destination equals the reset slot contents (all zero) produces no slot hit.
- R2: Register map: slot k has its low word at address 2k and its high word at address 2k+1. Writing the high word activates slot k. Writing the low word deactivates it until the high word is written again.
- R3: Byte order: the first destination byte received maps to bits [7:0] of the slot low word and the sixth to bits [15:8] of the high word. For example, low 0x87654321 with high 0x0000CBA9 matches bytes 21,43,65,87,A9,CB. A hit on active slot k sets `slotHit[k]`.
- R4: An all-ones destination sets `bcastHit` and `accept` unless configuration bit 0 (no-broadcast, address 11) is 1.
- R5: The hash index bit i is the XOR of destination bits i, i+6, …, i+42. Destination bit 0 is the LSB of the first byte. The table low word (address 8) holds entries 31:0 and the high word (address 9) holds entries 63:32. A set entry gives a hash hit.
- R6: The group flag is the LSB of the first destination byte (1 = multicast). A hash hit counts only for multicast frames when configuration bit 2 is set, and only for unicast frames when configuration bit 1 is set.
- R7: The type value (address 11 − 1 = 10, bits [15:0]) is compared with bytes 13 and 14 of the frame, the first in bits [15:8]. `typeValid` rises one clock after the fourteenth byte, and `typeHit` reports equality.
- R8: `decValid` rises one clock after the sixth destination byte and holds, with all result flags stable, until the next frame start. `accept` is the OR of all slot hits, the broadcast hit and the enabled hash hit.
- R9: Register writes made after a frame's first byte do not affect that frame's results. They do affect the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive byte qualifier |
| rxStart | input | 1 | First byte of a frame (with rxValid) |
| rxData | input | 8 | Receive byte |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Register write data |
| decValid | output | 1 | Address decision valid |
| accept | output | 1 | Frame accepted |
| slotHit | output | 4 | Per-slot exact match |
| bcastHit | output | 1 | Broadcast accepted |
| hashHit | output | 1 | Enabled hash hit |
| typeValid | output | 1 | Type comparison valid |
| typeHit | output | 1 | Type field equals type value |

## Verification
The address results are due on the first clock edge after the sixth byte, and the type results on the edge after the fourteenth byte. The bench drives each byte on a falling edge. It samples a few nanoseconds after the rising edge that registers that byte. One directed scenario steps through the frame byte by byte to confirm that `decValid` is still low after the fifth byte, rises after the sixth and `typeValid` is low after the thirteenth byte. Every other scenario reads the held results once the frame has ended, because R8 keeps them stable until the next start.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int MAC_W      = 48;
  localparam int MAC_BYTES  = MAC_W / 8;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_W     = 1 << HASH_IDX_W;
  localparam int TYPE_W     = 16;
  localparam int FOLDS      = MAC_W / HASH_IDX_W;

  typedef struct packed {
    logic mcastHashEn;
    logic ucastHashEn;
    logic noBcast;
  } cfg_t;

  typedef struct packed {
    logic       frameStart;
    logic       daWe;
    logic [2:0] daSel;
    logic       daDone;
    logic       typeHiWe;
    logic       typeDone;
  } strobes_t;

  function automatic logic [HASH_IDX_W-1:0] foldHash(input logic [MAC_W-1:0] a);
    logic [HASH_IDX_W-1:0] r;
    for (int i = 0; i < HASH_IDX_W; i++) begin
      r[i] = 1'b0;
      for (int j = 0; j < FOLDS; j++) r[i] = r[i] ^ a[i + HASH_IDX_W*j];
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxValid,
  input  logic     rxStart,
  output strobes_t st
);

  localparam logic [3:0] LAST_DA_IDX = 4'(MAC_BYTES - 1);
  localparam logic [3:0] TYPE_HI_IDX = 4'(2*MAC_BYTES);
  localparam logic [3:0] TYPE_LO_IDX = 4'(2*MAC_BYTES + 1);

  logic [3:0] idx;
  logic       inFrame;
  logic [3:0] curIdx;
  logic       take;
  logic       startNow;

  assign startNow = rxValid && rxStart;
  assign curIdx   = rxStart ? 4'd0 : idx;
  assign take     = startNow || (rxValid && inFrame && idx <= TYPE_LO_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= 4'd0;
      inFrame <= 1'b0;
    end else if (startNow) begin
      idx     <= 4'd1;
      inFrame <= 1'b1;
    end else if (take) begin
      idx <= idx + 4'd1;
      if (idx == TYPE_LO_IDX) inFrame <= 1'b0;
    end
  end

  always_comb begin
    st.frameStart = startNow;
    st.daWe       = take && (curIdx <= LAST_DA_IDX);
    st.daSel      = curIdx[2:0];
    st.daDone     = take && (curIdx == LAST_DA_IDX);
    st.typeHiWe   = take && (curIdx == TYPE_HI_IDX);
    st.typeDone   = take && (curIdx == TYPE_LO_IDX);
  end

  // R8: the byte counter never runs past the type field
  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    idx <= TYPE_LO_IDX + 4'd1);

  // R7: at most one field strobe per byte
  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.daDone, st.typeHiWe, st.typeDone}));

endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AW-1:0]               wrAddr,
  input  logic [DW-1:0]               wrData,
  output logic [SLOTS-1:0][MAC_W-1:0] slotAddr,
  output logic [SLOTS-1:0]            slotActive,
  output logic [HASH_W-1:0]           hashTab,
  output logic [TYPE_W-1:0]           typeId,
  output cfg_t                        cfg
);

  localparam logic [AW-1:0] HASH_LO_A = AW'(2*SLOTS);
  localparam logic [AW-1:0] HASH_HI_A = AW'(2*SLOTS + 1);
  localparam logic [AW-1:0] TYPE_A    = AW'(2*SLOTS + 2);
  localparam logic [AW-1:0] CFG_A     = AW'(2*SLOTS + 3);
  localparam int            LOW_W     = 32;
  localparam int            HIGH_W    = MAC_W - LOW_W;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic [AW-1:0] LO_A = AW'(2*k);
    localparam logic [AW-1:0] HI_A = AW'(2*k + 1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[k]   <= '0;
        slotActive[k] <= 1'b0;
      end else if (wrEn && wrAddr == LO_A) begin
        slotAddr[k][LOW_W-1:0] <= wrData[LOW_W-1:0];
        slotActive[k]          <= 1'b0;
      end else if (wrEn && wrAddr == HI_A) begin
        slotAddr[k][MAC_W-1:LOW_W] <= wrData[HIGH_W-1:0];
        slotActive[k]              <= 1'b1;
      end
    end

    p_disarm_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == LO_A) |=> !slotActive[k]);
    p_arm_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == HI_A) |=> slotActive[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hashTab <= '0;
      typeId  <= '0;
      cfg     <= '0;
    end else if (wrEn) begin
      if (wrAddr == HASH_LO_A) hashTab[31:0]  <= wrData;
      if (wrAddr == HASH_HI_A) hashTab[63:32] <= wrData;
      if (wrAddr == TYPE_A)    typeId         <= wrData[TYPE_W-1:0];
      if (wrAddr == CFG_A)     cfg            <= wrData[2:0];
    end
  end

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    st,
  input  logic [7:0]                  rxData,
  input  logic [SLOTS-1:0][MAC_W-1:0] slotAddr,
  input  logic [SLOTS-1:0]            slotActive,
  input  logic [HASH_W-1:0]           hashTab,
  input  logic [TYPE_W-1:0]           typeId,
  input  cfg_t                        cfg,
  output logic                        decValid,
  output logic                        accept,
  output logic [SLOTS-1:0]            slotHit,
  output logic                        bcastHit,
  output logic                        hashHit,
  output logic                        typeValid,
  output logic                        typeHit
);

  localparam int BUF_BYTES = MAC_BYTES - 1;

  logic [SLOTS-1:0][MAC_W-1:0] snapAddr;
  logic [SLOTS-1:0]            snapActive;
  logic [HASH_W-1:0]           snapHash;
  logic [TYPE_W-1:0]           snapType;
  cfg_t                        snapCfg;

  logic [8*BUF_BYTES-1:0]  daBuf;
  logic [MAC_W-1:0]        daFull;
  logic [7:0]              typeHi;
  logic [SLOTS-1:0]        slotMatch;
  logic                    isBcast;
  logic                    isMcast;
  logic [HASH_IDX_W-1:0]   hIdx;
  logic                    hashOk;

  // settings frozen at the first byte of each frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapAddr   <= '0;
      snapActive <= '0;
      snapHash   <= '0;
      snapType   <= '0;
      snapCfg    <= '0;
    end else if (st.frameStart) begin
      snapAddr   <= slotAddr;
      snapActive <= slotActive;
      snapHash   <= hashTab;
      snapType   <= typeId;
      snapCfg    <= cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      daBuf  <= '0;
      typeHi <= '0;
    end else begin
      for (int b = 0; b < BUF_BYTES; b++)
        if (st.daWe && st.daSel == 3'(b)) daBuf[8*b +: 8] <= rxData;
      if (st.typeHiWe) typeHi <= rxData;
    end
  end

  assign daFull = {rxData, daBuf};

  for (genvar k = 0; k < SLOTS; k++) begin : g_cmp
    assign slotMatch[k] = snapActive[k] && (snapAddr[k] == daFull);
  end

  always_comb begin
    isBcast = (&daFull) && !snapCfg.noBcast;
    isMcast = daFull[0];
    hIdx    = foldHash(daFull);
    hashOk  = snapHash[hIdx] && (isMcast ? snapCfg.mcastHashEn : snapCfg.ucastHashEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.frameStart) begin
      decValid  <= 1'b0;
      accept    <= 1'b0;
      slotHit   <= '0;
      bcastHit  <= 1'b0;
      hashHit   <= 1'b0;
      typeValid <= 1'b0;
      typeHit   <= 1'b0;
    end else begin
      if (st.daDone) begin
        decValid <= 1'b1;
        slotHit  <= slotMatch;
        bcastHit <= isBcast;
        hashHit  <= hashOk;
        accept   <= (|slotMatch) || isBcast || hashOk;
      end
      if (st.typeDone) begin
        typeValid <= 1'b1;
        typeHit   <= ({typeHi, rxData} == snapType);
      end
    end
  end

  p_dec_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decValid) |-> $past(st.daDone));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !st.frameStart) |=> ($stable(accept) && $stable(slotHit) && decValid));

  p_bcast_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    bcastHit |-> !snapCfg.noBcast);

  p_type_after_da_r7: assert property (@(posedge clk) disable iff (!rstN)
    typeValid |-> decValid);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxStart,
  input  logic [7:0]       rxData,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  output logic             decValid,
  output logic             accept,
  output logic [SLOTS-1:0] slotHit,
  output logic             bcastHit,
  output logic             hashHit,
  output logic             typeValid,
  output logic             typeHit
);

  strobes_t                    st;
  logic [SLOTS-1:0][MAC_W-1:0] slotAddr;
  logic [SLOTS-1:0]            slotActive;
  logic [HASH_W-1:0]           hashTab;
  logic [TYPE_W-1:0]           typeId;
  cfg_t                        cfg;

  rxf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxStart(rxStart), .st(st)
  );

  rxf_regs #(.SLOTS(SLOTS), .AW(AW), .DW(DW)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slotAddr(slotAddr), .slotActive(slotActive), .hashTab(hashTab),
    .typeId(typeId), .cfg(cfg)
  );

  rxf_datapath #(.SLOTS(SLOTS)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .rxData(rxData),
    .slotAddr(slotAddr), .slotActive(slotActive), .hashTab(hashTab),
    .typeId(typeId), .cfg(cfg),
    .decValid(decValid), .accept(accept), .slotHit(slotHit),
    .bcastHit(bcastHit), .hashHit(hashHit),
    .typeValid(typeValid), .typeHit(typeHit)
  );

endmodule

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic        rxStart = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = 4'h0;
  logic [31:0] wrData = 32'h0;
  logic        decValid, accept, bcastHit, hashHit, typeValid, typeHit;
  logic [3:0]  slotHit;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxStart(rxStart), .rxData(rxData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .decValid(decValid), .accept(accept), .slotHit(slotHit),
    .bcastHit(bcastHit), .hashHit(hashHit), .typeValid(typeValid), .typeHit(typeHit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic s);
    @(negedge clk);
    rxValid = 1'b1; rxStart = s; rxData = b;
    @(posedge clk);
    #1 rxValid = 1'b0; rxStart = 1'b0;
  endtask

  task automatic sendRest(input logic [47:0] da, input logic [15:0] typ);
    for (int i = 1; i < 6; i++) sendByte(da[8*i +: 8], 1'b0);
    for (int i = 0; i < 6; i++) sendByte(8'h00, 1'b0);
    sendByte(typ[15:8], 1'b0);
    sendByte(typ[7:0], 1'b0);
    #4;
  endtask

  task automatic sendFrame(input logic [47:0] da, input logic [15:0] typ);
    sendByte(da[7:0], 1'b1);
    sendRest(da, typ);
  endtask

  function automatic logic [5:0] refHash(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int b = 0; b < 48; b++) r[b % 6] = r[b % 6] ^ a[b];
    return r;
  endfunction

  task automatic loadHashBit(input logic [5:0] idx);
    logic [63:0] t = 64'd1 << idx;
    regWrite(4'd8, t[31:0]);
    regWrite(4'd9, t[63:32]);
  endtask

  task automatic testReset();
    check("R1 decValid after reset", decValid, 0);
    check("R1 typeValid after reset", typeValid, 0);
    sendFrame(48'h0, 16'h0);
    check("R1 no slot hit when inactive", slotHit, 0);
    check("R1 no accept", accept, 0);
  endtask

  task automatic testExact();
    regWrite(4'd2, 32'h87654321);
    regWrite(4'd3, 32'h0000CBA9);
    regWrite(4'd10, 32'h00004321);
    sendFrame(48'hCBA987654321, 16'h4321);
    check("R3 slot1 hit", slotHit, 4'b0010);
    check("R8 accept on slot hit", accept, 1);
    check("R7 typeValid", typeValid, 1);
    check("R7 type match", typeHit, 1);
    sendFrame(48'hCBA987654321, 16'h4322);
    check("R7 type mismatch", typeHit, 0);
    sendFrame(48'hCBA987654320, 16'h4321);
    check("R3 off-by-one address misses", slotHit, 0);
  endtask

  task automatic testArm();
    regWrite(4'd2, 32'h87654321);
    sendFrame(48'hCBA987654321, 16'h0);
    check("R2 low write disarms", slotHit, 0);
    check("R2 disarmed no accept", accept, 0);
    regWrite(4'd3, 32'h0000CBA9);
    sendFrame(48'hCBA987654321, 16'h0);
    check("R2 high write arms", slotHit, 4'b0010);
  endtask

  task automatic testBcast();
    sendFrame(48'hFFFFFFFFFFFF, 16'h0);
    check("R4 broadcast hit", bcastHit, 1);
    check("R4 broadcast accept", accept, 1);
    regWrite(4'd11, 32'h1);
    sendFrame(48'hFFFFFFFFFFFF, 16'h0);
    check("R4 no-broadcast blocks", bcastHit, 0);
    check("R4 no-broadcast no accept", accept, 0);
    regWrite(4'd11, 32'h0);
  endtask

  task automatic testHash();
    logic [47:0] uc = 48'h544433221102;
    logic [47:0] mc = 48'hFB00005E0001;
    loadHashBit(refHash(uc));
    sendFrame(uc, 16'h0);
    check("R6 unicast hash disabled", hashHit, 0);
    regWrite(4'd11, 32'h2);
    sendFrame(uc, 16'h0);
    check("R5 unicast hash hit", hashHit, 1);
    check("R5 hash accept", accept, 1);
    loadHashBit(refHash(uc) ^ 6'd1);
    sendFrame(uc, 16'h0);
    check("R5 neighbour entry misses", hashHit, 0);
    loadHashBit(refHash(mc));
    sendFrame(mc, 16'h0);
    check("R6 multicast with only unicast enable", hashHit, 0);
    regWrite(4'd11, 32'h4);
    sendFrame(mc, 16'h0);
    check("R6 multicast hash hit", hashHit, 1);
    regWrite(4'd11, 32'h0);
  endtask

  task automatic testTiming();
    logic [47:0] da = 48'hCBA987654321;
    sendByte(da[7:0], 1'b1);
    check("R8 start clears decValid", decValid, 0);
    for (int i = 1; i < 5; i++) sendByte(da[8*i +: 8], 1'b0);
    #4 check("R8 not valid after fifth byte", decValid, 0);
    sendByte(da[47:40], 1'b0);
    #4 check("R8 valid after sixth byte", decValid, 1);
    check("R8 slot result at sixth byte", slotHit, 4'b0010);
    for (int i = 0; i < 7; i++) sendByte(8'h00, 1'b0);
    #4 check("R7 typeValid low before last type byte", typeValid, 0);
    check("R8 decision held", decValid, 1);
    sendByte(8'h00, 1'b0);
    #4 check("R7 typeValid after fourteenth byte", typeValid, 1);
  endtask

  task automatic testMidWrite();
    logic [47:0] da = 48'hF0EEDDCCBBAA;
    sendByte(da[7:0], 1'b1);
    regWrite(4'd4, 32'hDDCCBBAA);
    regWrite(4'd5, 32'h0000F0EE);
    sendRest(da, 16'h0);
    check("R9 mid-frame arm ignored", slotHit, 0);
    sendFrame(da, 16'h0);
    check("R9 arm applies next frame", slotHit, 4'b0100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #4;
    testReset();
    testExact();
    testArm();
    testBcast();
    testHash();
    testTiming();
    testMidWrite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule